// File: doc/BRIEF.md
# Constant-Delay TDM Time-Slot Interchanger

This block reorders the byte-wide channels of one time-division multiplexed stream. A frame pulse marks channel 0 and a channel strobe marks each byte. A connection table picks, for every output channel, the input channel whose byte it carries. Each frame holds 32, 64 or 128 channels, set by a rate select.

Every path through the switch has a fixed latency. That latency does not depend on which input feeds which output. Input bytes are written into a ring of frame pages, one page per frame. The read side takes its byte from a page a fixed number of frames behind the output frame. Two programmable channel delays move the logical channel grid away from the frame pulse. The input-side delay moves it on the receive side and the output-side delay moves it on the transmit side. This changes the latency by a whole number of channel slots.

Changes to the connection table are staged. A change takes effect at the next frame boundary. Any location that has not yet received a byte since reset reads as the idle pattern.

Top module: `tdm_const_delay_switch`

## Requirements
- R1: With both channel delays disabled, a byte sampled at input channel m appears on output channel n exactly 2 frames + (n − m) channel slots later.
- R2: With only the input delay enabled (value α), the latency is 3 frames − α + (n − m) slots.
- R3: With only the output delay enabled (value β), the latency is 2 frames + β + (n − m) slots.
- R4: With both delays enabled, the latency is 3 frames − α + β + (n − m) slots.
- R5: `rate` selects the frame length: 0 gives 32 channels, 1 gives 64, and 2 or 3 give 128.
- R6: An enabled delay value above (frame length − 1) acts as frame length − 1. A disabled delay acts as 0.
- R7: A table write reaches the read path at the next strobe that carries the frame pulse. A write issued in that same strobe cycle waits for the boundary after it.
- R8: `dout` is 0xFF until the first frame pulse. Any output slot whose source byte has not been written since reset also reads 0xFF.
- R9: After reset, `dout` is 0xFF and every table entry n maps to input channel n.
- R10: `dout` takes its new value in the clock cycle after a strobe. It holds that value in every cycle that follows a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate | input | 2 | Frame length select (R5) |
| frame_pulse | input | 1 | Marks channel 0. Sampled only together with `ch_strobe` |
| ch_strobe | input | 1 | One-cycle strobe per channel slot |
| din | input | 8 | Input byte for the current slot |
| cm_we | input | 1 | Connection table write enable |
| cm_addr | input | 7 | Output channel being mapped |
| cm_src | input | 7 | Input channel feeding it |
| in_dly_en | input | 1 | Input-side channel delay enable |
| in_dly | input | 7 | Input-side channel delay α |
| out_dly_en | input | 1 | Output-side channel delay enable |
| out_dly | input | 7 | Output-side channel delay β |
| dout | output | 8 | Switched output byte |

## Verification
A connection table write and a frame boundary can land in the same clock cycle. The bench provokes this by driving `cm_we` on the strobe that carries the frame pulse. The bench's reference model commits the old staged table to that boundary first and records the new write afterwards. The new mapping must therefore appear only one frame later. Every sampled `dout` is compared with that model, so a write that takes effect early or is lost is reported as an R7 mismatch.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int TSI_MAXCH = 128;
  localparam int TSI_CHW   = $clog2(TSI_MAXCH);
  localparam int TSI_PAGES = 8;
  localparam int TSI_PGW   = $clog2(TSI_PAGES);

  typedef logic [TSI_CHW-1:0] ch_t;
  typedef logic [TSI_PGW-1:0] pg_t;
  typedef struct packed {
    pg_t page;
    ch_t ch;
  } pos_t;

  // channels per frame for a rate code
  function automatic logic [TSI_CHW:0] frame_len(input logic [1:0] rate);
    case (rate)
      2'd0:    return (TSI_CHW+1)'(32);
      2'd1:    return (TSI_CHW+1)'(64);
      default: return (TSI_CHW+1)'(128);
    endcase
  endfunction

  // delay actually applied: zero when off, clamped to frame length - 1
  function automatic ch_t eff_delay(input logic en, input ch_t val, input logic [1:0] rate);
    logic [TSI_CHW:0] lim;
    lim = frame_len(rate) - (TSI_CHW+1)'(1);
    if (!en) return '0;
    if ({1'b0, val} > lim) return lim[TSI_CHW-1:0];
    return val;
  endfunction

  // move a physical (frame, slot) position back by dly slots
  function automatic pos_t step_back(input pg_t frame, input ch_t slot, input ch_t dly,
                                     input logic [1:0] rate);
    pos_t r;
    logic [TSI_CHW:0] wrapped;
    if (slot >= dly) begin
      r.page = frame;
      r.ch   = slot - dly;
    end else begin
      wrapped = {1'b0, slot} + frame_len(rate) - {1'b0, dly};
      r.page  = frame - pg_t'(1);
      r.ch    = wrapped[TSI_CHW-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
  import tsi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ch_strobe,
  input  logic frame_pulse,
  output logic boundary,
  output logic tick,
  output logic synced_q,
  output ch_t  cur_slot,
  output pg_t  cur_frame
);
  ch_t slot_q;
  pg_t frame_q;

  assign boundary  = ch_strobe & frame_pulse;
  assign tick      = ch_strobe & (synced_q | frame_pulse);
  assign cur_slot  = boundary ? '0 : slot_q + ch_t'(1);
  assign cur_frame = boundary ? frame_q + pg_t'(1) : frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      frame_q  <= '0;
      synced_q <= 1'b0;
    end else if (tick) begin
      slot_q   <= cur_slot;
      frame_q  <= cur_frame;
      synced_q <= 1'b1;
    end
  end

  AST_SYNC_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> synced_q); // R8
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int N   = 128,
  parameter int CHW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [CHW-1:0] waddr,
  input  logic [CHW-1:0] wdata,
  input  logic           commit,
  input  logic [CHW-1:0] rd_idx,
  output logic [CHW-1:0] rd_ch
);
  logic [N-1:0][CHW-1:0] pend_q;
  logic [N-1:0][CHW-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        pend_q[i] <= CHW'(i);
        act_q[i]  <= CHW'(i);
      end
    end else begin
      if (commit) act_q <= pend_q;
      if (we) pend_q[waddr] <= wdata;
    end
  end

  // on the boundary strobe the staged table is already the one in force
  assign rd_ch = commit ? pend_q[rd_idx] : act_q[rd_idx];

  AST_CM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> act_q == $past(pend_q)); // R7
  AST_CM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q)); // R7
endmodule

// File: rtl/tsi_page_buf.sv
module tsi_page_buf #(
  parameter int DW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (we) vld_q[waddr] <= 1'b1;
  end

  assign rdata = vld_q[raddr] ? mem[raddr] : {DW{1'b1}};

  AST_WRITE_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> vld_q[$past(waddr)]); // R8
endmodule

// File: rtl/tdm_const_delay_switch.sv
module tdm_const_delay_switch
  import tsi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         rate,
  input  logic               frame_pulse,
  input  logic               ch_strobe,
  input  logic [DW-1:0]      din,
  input  logic               cm_we,
  input  logic [TSI_CHW-1:0] cm_addr,
  input  logic [TSI_CHW-1:0] cm_src,
  input  logic               in_dly_en,
  input  logic [TSI_CHW-1:0] in_dly,
  input  logic               out_dly_en,
  input  logic [TSI_CHW-1:0] out_dly,
  output logic [DW-1:0]      dout
);
  localparam int AW = TSI_PGW + TSI_CHW;

  logic boundary, tick, synced_q;
  ch_t  cur_slot, a_eff, b_eff, src_ch;
  pg_t  cur_frame, rd_page;
  pos_t in_pos, out_pos;
  logic [DW-1:0] rdata, dout_q;

  tsi_slot_timer u_timer (
    .clk(clk), .rst_n(rst_n), .ch_strobe(ch_strobe), .frame_pulse(frame_pulse),
    .boundary(boundary), .tick(tick), .synced_q(synced_q),
    .cur_slot(cur_slot), .cur_frame(cur_frame)
  );

  assign a_eff   = eff_delay(in_dly_en, in_dly, rate);
  assign b_eff   = eff_delay(out_dly_en, out_dly, rate);
  assign in_pos  = step_back(cur_frame, cur_slot, a_eff, rate);
  assign out_pos = step_back(cur_frame, cur_slot, b_eff, rate);
  // an input delay costs one extra whole frame of buffering
  assign rd_page = out_pos.page - (in_dly_en ? pg_t'(3) : pg_t'(2));

  tsi_conn_mem #(.N(TSI_MAXCH), .CHW(TSI_CHW)) u_cmem (
    .clk(clk), .rst_n(rst_n), .we(cm_we), .waddr(cm_addr), .wdata(cm_src),
    .commit(boundary), .rd_idx(out_pos.ch), .rd_ch(src_ch)
  );

  tsi_page_buf #(.DW(DW), .AW(AW)) u_pages (
    .clk(clk), .rst_n(rst_n), .we(tick), .waddr(AW'(in_pos)), .wdata(din),
    .raddr({rd_page, src_ch}), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= {DW{1'b1}};
    else if (tick) dout_q <= rdata;
  end

  assign dout = dout_q;

  AST_DOUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_strobe |=> $stable(dout)); // R10
  AST_IDLE_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_q |-> dout == {DW{1'b1}}); // R8
  AST_DELAY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, a_eff} < frame_len(rate)) && ({1'b0, b_eff} < frame_len(rate))); // R6
endmodule

// File: tb/sim_tdm_const_delay_switch.sv
`timescale 1ns/1ps
module sim_tdm_const_delay_switch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] rate;
  logic       frame_pulse, ch_strobe, cm_we, in_dly_en, out_dly_en;
  logic [7:0] din;
  logic [6:0] cm_addr, cm_src, in_dly, out_dly;
  logic [7:0] dout;

  int tests = 0;
  int fails = 0;
  logic [7:0] exp_q;

  always #2 clk = ~clk;

  tdm_const_delay_switch u0 (
    .clk(clk), .rst_n(rst_n), .rate(rate), .frame_pulse(frame_pulse),
    .ch_strobe(ch_strobe), .din(din), .cm_we(cm_we), .cm_addr(cm_addr),
    .cm_src(cm_src), .in_dly_en(in_dly_en), .in_dly(in_dly),
    .out_dly_en(out_dly_en), .out_dly(out_dly), .dout(dout)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s dout=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_scn(input int r, input bit ae, input int av, input bit be, input int bv,
                         input int frames, input string tag, input int cmode);
    int n, a_use, b_use, k, abs_pos, lo_abs, lo, oc, m, src;
    bit synced;
    int cm_pend[128];
    int cm_act[128];
    logic [7:0] hist[int];
    bit wr;
    int wa, wd;
    n = (r == 0) ? 32 : (r == 1) ? 64 : 128;
    a_use = ae ? ((av > n - 1) ? n - 1 : av) : 0;
    b_use = be ? ((bv > n - 1) ? n - 1 : bv) : 0;
    k = ae ? 3 : 2;
    for (int i = 0; i < 128; i++) begin cm_pend[i] = i; cm_act[i] = i; end
    synced = 0; abs_pos = 0;
    rate = r[1:0]; in_dly_en = ae; in_dly = av[6:0]; out_dly_en = be; out_dly = bv[6:0];
    ch_strobe = 0; frame_pulse = 0; cm_we = 0; cm_addr = 0; cm_src = 0; din = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dout, 8'hFF, "R9 reset");
    exp_q = 8'hFF;
    // a few strobes before the first frame pulse (R8), then whole frames
    for (int t = -3; t < frames * n; t++) begin
      int s;
      s = (t < 0) ? 1 : t % n;
      @(negedge clk);
      chk(dout, exp_q, "R10 hold");
      ch_strobe = 1;
      frame_pulse = (t >= 0) && (s == 0);
      din = 8'($urandom);
      wr = 0; wa = 0; wd = 0;
      if (cmode == 1 && t >= 2 * n && t < 3 * n) begin wr = 1; wa = s; wd = n - 1 - s; end
      if (cmode == 2 && t == 3 * n)             begin wr = 1; wa = 3; wd = 10; end // R7 same-cycle case
      if (cmode == 2 && t == 2 * n + 40)        begin wr = 1; wa = 5; wd = 0; end
      cm_we = wr; cm_addr = wa[6:0]; cm_src = wd[6:0];
      // reference model
      if (frame_pulse) begin
        if (!synced) begin synced = 1; abs_pos = 0; end
        else abs_pos++;
        for (int i = 0; i < 128; i++) cm_act[i] = cm_pend[i];
      end else if (synced) abs_pos++;
      if (synced) begin
        hist[abs_pos] = din;
        lo_abs = abs_pos - b_use;
        lo = (lo_abs + 8 * n) / n - 8;
        oc = lo_abs - lo * n;
        m = cm_act[oc];
        src = (lo - k) * n + m + a_use;
        exp_q = (src >= 0 && hist.exists(src)) ? hist[src] : 8'hFF;
      end else exp_q = 8'hFF;
      if (wr) cm_pend[wa] = wd;
      @(negedge clk);
      chk(dout, exp_q, synced ? tag : "R8 presync");
      ch_strobe = 0; frame_pulse = 0; cm_we = 0;
    end
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    run_scn(0, 0, 0,   0, 0,   6, "R1 R5 R7 R9", 1);
    run_scn(1, 1, 5,   0, 0,   6, "R2 R5", 0);
    run_scn(2, 0, 0,   1, 100, 6, "R3 R5", 0);
    run_scn(0, 1, 7,   1, 20,  7, "R4 R7", 2);
    run_scn(0, 1, 100, 1, 127, 7, "R6 R4", 1);
    run_scn(3, 1, 0,   1, 1,   5, "R5 R4", 0);
    run_scn(1, 0, 90,  1, 3,   5, "R6 R3", 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule